// File: doc/BRIEF.md
# Set-Tagged Adder Pipeline Supervisor

This block supervises a p-stage pipelined adder that accumulates several independent vectors as one continuous stream. It hands out a set identifier for the vector now arriving. Every accepted input word carries that identifier. The identifier advances by one after the final word of a vector.

Whenever control logic launches an operand pair into the adder, it strobes the supervisor with the two operand tags. The supervisor carries a valid bit and the pair's tag down a delay line as long as the adder pipeline. From that line it reports four things:

- when a sum emerges at the tail, and which set that sum belongs to;
- whether that set matches the vector now arriving;
- whether another operation of the same set is still inside the adder;
- whether the adder has been idle long enough to be empty.

A controller uses these flags to decide where a fresh sum goes: back into the adder with a new input, paired with a buffered partial, or parked until a partner of its own set appears. At most about five thirds of p sets can be in flight at once. The identifier is sized from that bound and simply wraps.

Top module: `set_tag_supervisor`

## Requirements
- R1: While reset is high and on the first cycle after it, the outputs hold these values: `in_tag` 0, `sum_valid` 0, `sum_tag` 0, both match flags 0, and `pipe_idle` 1.
- R2: `in_tag` rises by exactly one, modulo its width, in the cycle after a cycle in which `in_valid` and `in_last` are both high. In every other case it keeps its value.
- R3: `in_tag` is SID_W bits wide, where SID_W = clog2(ceil(5P/3)+1). That is 5 bits for the default P = 11. After 31 the tag wraps to 0.
- R4: An `issue` strobe in cycle c makes `sum_valid` high in cycle c+P. In that cycle `sum_tag` equals the `issue_tag_a` that was sampled in cycle c. With no issue in cycle c, `sum_valid` is low in cycle c+P.
- R5: In every cycle, `sum_in_match` is high exactly when `sum_valid` is high and `sum_tag` equals `in_tag`.
- R6: In every cycle, `sum_inflight_match` is high exactly when `sum_valid` is high and at least one of the P-1 younger pipeline slots holds an issue with the same tag. Slots without an issue are ignored, whatever tag value they carry.
- R7: `pipe_idle` is high in cycle c exactly when `issue` was low in all of the cycles c-P through c-1.
- R8: The two tags of an issued pair name the same set. The tag that travels with the pair therefore equals `issue_tag_b` as well as `issue_tag_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An input word is presented this cycle |
| in_last | input | 1 | The presented word ends its vector |
| issue | input | 1 | An operand pair enters the adder this cycle |
| issue_tag_a | input | SID_W | Set tag of operand A of the pair |
| issue_tag_b | input | SID_W | Set tag of operand B of the pair |
| in_tag | output | SID_W | Set tag to attach to the word now arriving |
| sum_tag | output | SID_W | Set tag of the sum at the pipeline tail |
| sum_valid | output | 1 | A sum emerges from the adder this cycle |
| sum_in_match | output | 1 | The emerging sum belongs to the arriving vector |
| sum_inflight_match | output | 1 | Another operation of the sum's set is still in the adder |
| pipe_idle | output | 1 | No pair issued during the last P cycles |

## Verification
An issue sampled at one edge reaches `sum_valid` and `sum_tag` P cycles later. Both match flags and `pipe_idle` are registered from the next state, so they describe that same emerging slot in that same cycle. `in_tag` changes in the cycle after the last word of a vector.

The bench keeps a reference history of issues that advances at each rising edge. It compares every output at the following falling edge, so every result is checked in the cycle in which it is due and never earlier. Directed passes cover these cases:
- a lone issue with stale tags left in empty slots;
- a counter wrap;
- a same-set burst.

A seeded random stream then mixes issues, tag reuse and vector ends.

// File: rtl/set_tag_pkg.sv
package set_tag_pkg;

  // Most sets that can be alive in a P-stage pipeline at one time.
  function automatic int max_live_sets(input int p);
    return (5 * p + 2) / 3;
  endfunction

  // Tag width that can name every live set once.
  function automatic int sid_width(input int p);
    return $clog2(max_live_sets(p) + 1);
  endfunction

endpackage

// File: rtl/sid_counter.sv
module sid_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         advance,
  output logic [W-1:0] sid_q,
  output logic [W-1:0] sid_d
);

  // The next value is exported so that the flag logic can register
  // comparisons that line up with the tag now presented.
  always_comb begin
    sid_d = sid_q;
    if (advance) sid_d = sid_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) sid_q <= '0;
    else     sid_q <= sid_d;
  end

  // R2: the tag steps by one after the end of a vector.
  p_sid_step_r2: assert property (@(posedge clk) disable iff (rst)
    advance |=> sid_q == W'($past(sid_q) + 1'b1));

  // R2: the tag holds when no vector ends.
  p_sid_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(sid_q));

endmodule

// File: rtl/tag_delay_line.sv
module tag_delay_line #(
  parameter int P = 11,
  parameter int W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                issue,
  input  logic [W-1:0]        issue_tag,
  output logic [P-1:0]        stage_v,
  output logic [P-1:0][W-1:0] stage_tag,
  output logic [P-1:0]        nxt_v,
  output logic [P-1:0][W-1:0] nxt_tag
);

  // Slot 0 takes the new pair. Every later slot takes its predecessor.
  // Tags move even in slots that hold no issue; the valid bit qualifies them.
  assign nxt_v[0]   = issue;
  assign nxt_tag[0] = issue_tag;

  for (genvar i = 1; i < P; i++) begin : g_link
    assign nxt_v[i]   = stage_v[i-1];
    assign nxt_tag[i] = stage_tag[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_v   <= '0;
      stage_tag <= '0;
    end else begin
      stage_v   <= nxt_v;
      stage_tag <= nxt_tag;
    end
  end

  // R4: a pair appears in slot 0 one cycle after it is issued, with its tag.
  p_slot0_load_r4: assert property (@(posedge clk) disable iff (rst)
    issue |=> stage_v[0] && stage_tag[0] == $past(issue_tag));

endmodule

// File: rtl/tag_match_unit.sv
module tag_match_unit #(
  parameter int P = 11,
  parameter int W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [P-1:0]        nxt_v,
  input  logic [P-1:0][W-1:0] nxt_tag,
  input  logic [W-1:0]        nxt_sid,
  output logic                sum_in_match,
  output logic                sum_inflight_match,
  output logic                pipe_idle
);

  localparam int YOUNG = P - 1;

  logic           tail_v;
  logic [W-1:0]   tail_tag;
  logic [YOUNG-1:0] young_hit;

  assign tail_v   = nxt_v[P-1];
  assign tail_tag = nxt_tag[P-1];

  // One equality comparator per younger slot, each qualified by its valid bit.
  for (genvar i = 0; i < YOUNG; i++) begin : g_cmp
    assign young_hit[i] = nxt_v[i] && (nxt_tag[i] == tail_tag);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_in_match       <= 1'b0;
      sum_inflight_match <= 1'b0;
      pipe_idle          <= 1'b1;
    end else begin
      sum_in_match       <= tail_v && (tail_tag == nxt_sid);
      sum_inflight_match <= tail_v && (|young_hit);
      pipe_idle          <= ~(|nxt_v);
    end
  end

endmodule

// File: rtl/set_tag_supervisor.sv
module set_tag_supervisor #(
  parameter  int P     = 11,
  localparam int SID_W = set_tag_pkg::sid_width(P)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             issue,
  input  logic [SID_W-1:0] issue_tag_a,
  input  logic [SID_W-1:0] issue_tag_b,
  output logic [SID_W-1:0] in_tag,
  output logic [SID_W-1:0] sum_tag,
  output logic             sum_valid,
  output logic             sum_in_match,
  output logic             sum_inflight_match,
  output logic             pipe_idle
);

  logic [SID_W-1:0]        sid_d;
  logic [P-1:0]            stage_v;
  logic [P-1:0][SID_W-1:0] stage_tag;
  logic [P-1:0]            nxt_v;
  logic [P-1:0][SID_W-1:0] nxt_tag;

  sid_counter #(.W(SID_W)) u_sid (
    .clk     (clk),
    .rst     (rst),
    .advance (in_valid && in_last),
    .sid_q   (in_tag),
    .sid_d   (sid_d)
  );

  // Both operands of a pair share one set, so operand A's tag is carried.
  tag_delay_line #(.P(P), .W(SID_W)) u_line (
    .clk       (clk),
    .rst       (rst),
    .issue     (issue),
    .issue_tag (issue_tag_a),
    .stage_v   (stage_v),
    .stage_tag (stage_tag),
    .nxt_v     (nxt_v),
    .nxt_tag   (nxt_tag)
  );

  tag_match_unit #(.P(P), .W(SID_W)) u_match (
    .clk                (clk),
    .rst                (rst),
    .nxt_v              (nxt_v),
    .nxt_tag            (nxt_tag),
    .nxt_sid            (sid_d),
    .sum_in_match       (sum_in_match),
    .sum_inflight_match (sum_inflight_match),
    .pipe_idle          (pipe_idle)
  );

  assign sum_valid = stage_v[P-1];
  assign sum_tag   = stage_tag[P-1];

  // R8: an issued pair never mixes two sets.
  p_pair_same_set_r8: assert property (@(posedge clk) disable iff (rst)
    issue |-> issue_tag_a == issue_tag_b);

  // R5: the input-match flag implies a valid tail whose tag matches the arriving vector.
  p_in_match_sound_r5: assert property (@(posedge clk) disable iff (rst)
    sum_in_match |-> sum_valid && sum_tag == in_tag);

  // R5: a valid tail whose tag matches the arriving vector raises the input-match flag.
  p_in_match_full_r5: assert property (@(posedge clk) disable iff (rst)
    (sum_valid && sum_tag == in_tag) |-> sum_in_match);

  // R6: the in-flight match flag needs a valid tail and a busy pipeline.
  p_inflight_valid_r6: assert property (@(posedge clk) disable iff (rst)
    sum_inflight_match |-> sum_valid && !pipe_idle);

  // R7: an issue makes the pipeline busy in the next cycle.
  p_busy_after_issue_r7: assert property (@(posedge clk) disable iff (rst)
    issue |=> !pipe_idle);

  // R7: a valid tail is never reported from an idle pipeline.
  p_tail_not_idle_r7: assert property (@(posedge clk) disable iff (rst)
    sum_valid |-> !pipe_idle);

endmodule

// File: tb/set_tag_supervisor_test.sv
module set_tag_supervisor_test;

  localparam int P = 11;
  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid, in_last, issue;
  logic [W-1:0] issue_tag_a, issue_tag_b;
  logic [W-1:0] in_tag, sum_tag;
  logic         sum_valid, sum_in_match, sum_inflight_match, pipe_idle;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Reference history: index 0 is the youngest slot.
  bit           h_v  [P];
  logic [W-1:0] h_ta [P];
  logic [W-1:0] h_tb [P];
  logic [W-1:0] exp_sid;

  always #2.5 clk = ~clk;

  set_tag_supervisor #(.P(P)) uut (
    .clk                (clk),
    .rst                (rst),
    .in_valid           (in_valid),
    .in_last            (in_last),
    .issue              (issue),
    .issue_tag_a        (issue_tag_a),
    .issue_tag_b        (issue_tag_b),
    .in_tag             (in_tag),
    .sum_tag            (sum_tag),
    .sum_valid          (sum_valid),
    .sum_in_match       (sum_in_match),
    .sum_inflight_match (sum_inflight_match),
    .pipe_idle          (pipe_idle)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_inflight();
    if (!h_v[P-1]) return 0;
    for (int i = 0; i < P - 1; i++)
      if (h_v[i] && h_ta[i] == h_ta[P-1]) return 1;
    return 0;
  endfunction

  function automatic bit exp_idle();
    for (int i = 0; i < P; i++)
      if (h_v[i]) return 0;
    return 1;
  endfunction

  task automatic compare_all();
    check("R2 in_tag", in_tag, exp_sid);
    check("R4 sum_valid", sum_valid, h_v[P-1]);
    if (h_v[P-1]) begin
      check("R4 sum_tag", sum_tag, h_ta[P-1]);
      check("R8 sum_tag vs tag_b", sum_tag, h_tb[P-1]);
    end
    check("R5 sum_in_match", sum_in_match, h_v[P-1] && h_ta[P-1] == exp_sid);
    check("R6 sum_inflight_match", sum_inflight_match, exp_inflight());
    check("R7 pipe_idle", pipe_idle, exp_idle());
  endtask

  // Drive at the falling edge, let the design and the reference advance
  // at the rising edge, then compare at the next falling edge.
  task automatic cyc(input bit v, input bit l, input bit is, input logic [W-1:0] t);
    in_valid    = v;
    in_last     = l;
    issue       = is;
    issue_tag_a = t;
    issue_tag_b = t;
    @(posedge clk);
    for (int i = P - 1; i > 0; i--) begin
      h_v[i]  = h_v[i-1];
      h_ta[i] = h_ta[i-1];
      h_tb[i] = h_tb[i-1];
    end
    h_v[0]  = is;
    h_ta[0] = t;
    h_tb[0] = t;
    if (v && l) exp_sid = exp_sid + 1'b1;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250));
    rst = 1'b1;
    in_valid = 0;
    in_last = 0;
    issue = 0;
    issue_tag_a = '0;
    issue_tag_b = '0;
    exp_sid = '0;
    for (int i = 0; i < P; i++) begin
      h_v[i] = 0;
      h_ta[i] = '0;
      h_tb[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);

    // R1: values held during reset.
    check("R1 in_tag", in_tag, 0);
    check("R1 sum_valid", sum_valid, 0);
    check("R1 sum_tag", sum_tag, 0);
    check("R1 sum_in_match", sum_in_match, 0);
    check("R1 sum_inflight_match", sum_inflight_match, 0);
    check("R1 pipe_idle", pipe_idle, 1);
    rst = 1'b0;

    // R4, R6: one issue of tag 0. Empty slots carry the same stale tag,
    // so the in-flight flag has to stay low.
    cyc(1, 0, 1, 5'd0);
    for (int k = 0; k < P + 3; k++) begin
      cyc(0, 0, 0, 5'd0);
      if (k == P - 2) begin
        check("R4 lone issue emerges", sum_valid, 1);
        check("R6 stale tags ignored", sum_inflight_match, 0);
        check("R5 lone sum matches arriving set", sum_in_match, 1);
      end
    end
    check("R7 idle after drain", pipe_idle, 1);

    // R3: 32 ends of vectors bring the tag round to its start value.
    for (int k = 0; k < 32; k++) cyc(1, 1, 0, 5'd9);
    check("R3 wrap back to start", in_tag, 0);
    for (int k = 0; k < 31; k++) cyc(1, 1, 0, 5'd9);
    check("R3 top value", in_tag, 31);
    cyc(1, 1, 0, 5'd9);
    check("R3 wrap to zero", in_tag, 0);
    cyc(1, 0, 0, 5'd9);
    check("R2 no advance without last", in_tag, 0);
    cyc(0, 1, 0, 5'd9);
    check("R2 no advance without valid", in_tag, 0);

    // R6: a burst of one set keeps younger partners behind the tail.
    for (int k = 0; k < 6; k++) cyc(1, 0, 1, exp_sid);
    for (int k = 0; k < P; k++) begin
      cyc(0, 0, 0, 5'd3);
      if (k == P - 6) check("R6 burst partner in flight", sum_inflight_match, 1);
    end

    // Seeded random stream: tags drawn near the current set.
    for (int k = 0; k < 4000; k++) begin
      bit v, l, is;
      logic [W-1:0] t;
      v  = ($urandom % 4) != 0;
      l  = ($urandom % 6) == 0;
      is = ($urandom % 3) != 0;
      t  = exp_sid - W'($urandom % 3);
      cyc(v, l, is, t);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule